// File: doc/BRIEF.md
# Dual-Clock Byte-Pair Ingress Queue

This block takes a byte stream from a fast external source and hands it to a slower core clock domain. The two clocks have no fixed relationship. Incoming bytes are first packed in pairs into 16-bit words, so the shared storage is written at no more than half the byte rate. The words then go through a circular queue whose read and write pointers cross between the domains. The core drains the queue with a valid/ready handshake, at whatever pace it can manage.

A burst may end on an odd byte. A flush input handles this case: it pushes the half-filled word into the queue and tags it with a marker bit, which tells the consumer that only the low byte carries data. The source is never stalled. If a word arrives when the queue has no free slot, that word is discarded and a sticky overflow flag is raised. The flag is visible in the core domain and stays set until the core sends a one-cycle clear pulse.

Top module: `wide_ingress_fifo`

## Requirements
- R1: A completed pair appears as one word. The first byte received is in bits 7:0, the second byte is in bits 15:8, and `word_half_o` is 0.
- R2: A single pending byte never reaches the core unless a flush is given. Full-word writes into storage never happen on two consecutive input-clock cycles.
- R3: A flush while one byte is pending produces a word with `word_half_o`=1, the byte in bits 7:0 and bits 15:8 at zero. A byte that arrives together with a flush follows these rules:
  - If it would start a new pair, it becomes such a half word.
  - If it completes a pair, only the full word is produced.
  
  A flush with nothing pending produces no word.
- R4: Words reach the core in arrival order, with none lost or repeated, as long as storage has room.
- R5: While `word_valid_o`=1 and `word_ready_i`=0, the output word and its marker stay unchanged. If a further word is already stored, it is presented on the core cycle right after the accepting edge.
- R6: After reset, `word_valid_o` and `ovf_o` are 0. Once the last stored word is accepted, `word_valid_o` returns to 0.
- R7: With the core not reading, the block holds DEPTH words in storage plus one in the output register. Further words are dropped, and the words already held are delivered unchanged.
- R8: A dropped word sets the overflow flag. The flag shows on `ovf_o` and stays set until it is cleared.
- R9: A one-cycle `ovf_clr_i` pulse clears the flag. If no further drop occurs, `ovf_o` then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| in_clk_i | input | 1 | Input-side byte clock |
| byte_valid_i | input | 1 | A byte is present this input cycle |
| byte_data_i | input | 8 | Incoming byte |
| flush_i | input | 1 | Push a pending single byte as a half word |
| core_clk_i | input | 1 | Core-side clock |
| word_valid_o | output | 1 | Output word is valid |
| word_ready_i | input | 1 | Core accepts the output word |
| word_data_o | output | 16 | Output word |
| word_half_o | output | 1 | Only bits 7:0 of the word carry data |
| ovf_o | output | 1 | Sticky overflow flag, core domain |
| ovf_clr_i | input | 1 | One-cycle pulse that clears the overflow flag |

## Verification
A stored word reaches the output some core cycles after its write edge. The delay covers the two-flop pointer synchronizer and the output register, so it is about three to four core cycles and depends on clock phase. For this reason the bench does not predict the arrival cycle. Instead, on every core cycle it compares any presented word against the head of a behavioural queue. Handshake behaviour has an exact timing: the next word is due one core cycle after acceptance, and the bench samples at that cycle. The overflow flag appears within a few core cycles of a drop, and a clear takes effect within about six. The bench checks both only after fixed waits of 15 to 20 core cycles, which comfortably exceed those latencies.

// File: rtl/ingress_pkg.sv
package ingress_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic              half;
    logic [WORD_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import ingress_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              flush_i,
  output logic              emit_o,
  output entry_t            entry_o
);
  logic              have_q, have_d;
  logic [BYTE_W-1:0] lo_q, lo_d;

  always_comb begin
    emit_o  = 1'b0;
    entry_o = '0;
    have_d  = have_q;
    lo_d    = lo_q;
    if (byte_valid_i) begin
      if (have_q) begin
        emit_o       = 1'b1;
        entry_o.data = {byte_data_i, lo_q};
        have_d       = 1'b0;
      end else if (flush_i) begin
        emit_o       = 1'b1;
        entry_o.half = 1'b1;
        entry_o.data = {{BYTE_W{1'b0}}, byte_data_i};
      end else begin
        have_d = 1'b1;
        lo_d   = byte_data_i;
      end
    end else if (flush_i && have_q) begin
      emit_o       = 1'b1;
      entry_o.half = 1'b1;
      entry_o.data = {{BYTE_W{1'b0}}, lo_q};
      have_d       = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      have_q <= have_d;
      lo_q   <= lo_d;
    end
  end

  AST_FULL_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_o && !entry_o.half) |-> byte_valid_i); // R2
  AST_HALF_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_o && !entry_o.half) |=> !(emit_o && !entry_o.half)); // R2
  AST_HALF_NEEDS_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_o && entry_o.half) |-> flush_i); // R3
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_o && entry_o.half) |-> (entry_o.data[WORD_W-1:BYTE_W] == '0)); // R3
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW:0]   rq_gray_i,
  output logic          we_o,
  output logic          drop_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o
);
  logic [AW:0] wbin_q, wbin_nx, wgray_q;
  logic        full;

  // full: same slot index, opposite wrap (top two Gray bits inverted)
  assign full    = (wgray_q == {~rq_gray_i[AW:AW-1], rq_gray_i[AW-2:0]});
  assign we_o    = push_i && !full;
  assign drop_o  = push_i && full;
  assign wbin_nx = wbin_q + 1'b1;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  AST_GRAY_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R4
  AST_DROP_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> (wbin_q == $past(wbin_q))); // R7
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import ingress_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW:0]   wq_gray_i,
  input  entry_t        rd_entry_i,
  input  logic          ready_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          valid_o,
  output entry_t        entry_o
);
  logic [AW:0] rbin_q, rbin_nx, rgray_q;
  logic        valid_q, empty, fetch;
  entry_t      out_q;

  assign empty   = (rgray_q == wq_gray_i);
  assign fetch   = !empty && (!valid_q || ready_i);
  assign rbin_nx = rbin_q + 1'b1;
  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign valid_o = valid_q;
  assign entry_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else if (fetch) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      out_q   <= rd_entry_i;
      valid_q <= 1'b1;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(out_q))); // R5
  AST_EMPTY_DEASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ready_i && empty) |=> !valid_q); // R6
  AST_RGRAY_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R4
endmodule

// File: rtl/wide_ingress_fifo.sv
module wide_ingress_fifo #(
  parameter int unsigned DEPTH = 8  // power of two, at least 4
) (
  input  logic                           rst_ni,
  input  logic                           in_clk_i,
  input  logic                           byte_valid_i,
  input  logic [ingress_pkg::BYTE_W-1:0] byte_data_i,
  input  logic                           flush_i,
  input  logic                           core_clk_i,
  output logic                           word_valid_o,
  input  logic                           word_ready_i,
  output logic [ingress_pkg::WORD_W-1:0] word_data_o,
  output logic                           word_half_o,
  output logic                           ovf_o,
  input  logic                           ovf_clr_i
);
  import ingress_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  // input domain: packing and write side
  entry_t          pk_entry;
  logic            pk_emit, we, drop;
  logic [AW-1:0]   waddr, raddr;
  logic [PW-1:0]   wgray, rgray, wgray_core, rgray_in;

  pair_packer u_packer (
    .clk_i        (in_clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .flush_i      (flush_i),
    .emit_o       (pk_emit),
    .entry_o      (pk_entry)
  );

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .clk_i     (in_clk_i),
    .rst_ni    (rst_ni),
    .push_i    (pk_emit),
    .rq_gray_i (rgray_in),
    .we_o      (we),
    .drop_o    (drop),
    .waddr_o   (waddr),
    .wgray_o   (wgray)
  );

  gray_sync #(.W(PW)) u_r2w (
    .clk_i  (in_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_in)
  );

  gray_sync #(.W(PW)) u_w2r (
    .clk_i  (core_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_core)
  );

  // storage: written in input domain, read combinationally by core side
  entry_t mem_q [DEPTH];
  entry_t rd_entry, out_entry;

  always_ff @(posedge in_clk_i) begin
    if (we) mem_q[waddr] <= pk_entry;
  end

  assign rd_entry = mem_q[raddr];

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .clk_i      (core_clk_i),
    .rst_ni     (rst_ni),
    .wq_gray_i  (wgray_core),
    .rd_entry_i (rd_entry),
    .ready_i    (word_ready_i),
    .raddr_o    (raddr),
    .rgray_o    (rgray),
    .valid_o    (word_valid_o),
    .entry_o    (out_entry)
  );

  assign word_data_o = out_entry.data;
  assign word_half_o = out_entry.half;

  // overflow flag: set in input domain, clear request crosses as a toggle
  logic clr_tgl_q, clr_tgl_in, clr_seen_q, clr_edge, ovf_q, ovf_core;

  always_ff @(posedge core_clk_i or negedge rst_ni) begin
    if (!rst_ni)        clr_tgl_q <= 1'b0;
    else if (ovf_clr_i) clr_tgl_q <= ~clr_tgl_q;
  end

  gray_sync #(.W(1)) u_clr (
    .clk_i  (in_clk_i),
    .rst_ni (rst_ni),
    .d_i    (clr_tgl_q),
    .q_o    (clr_tgl_in)
  );

  assign clr_edge = clr_tgl_in ^ clr_seen_q;

  always_ff @(posedge in_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_seen_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      clr_seen_q <= clr_tgl_in;
      if (drop)          ovf_q <= 1'b1;  // a drop beats a concurrent clear
      else if (clr_edge) ovf_q <= 1'b0;
    end
  end

  gray_sync #(.W(1)) u_ovf (
    .clk_i  (core_clk_i),
    .rst_ni (rst_ni),
    .d_i    (ovf_q),
    .q_o    (ovf_core)
  );

  assign ovf_o = ovf_core;

  AST_DROP_SETS_OVF: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    drop |=> ovf_q); // R8
  AST_OVF_STICKY: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_edge) |=> ovf_q); // R8
  AST_OVF_CLEARS: assert property (@(posedge in_clk_i) disable iff (!rst_ni)
    (clr_edge && !drop) |=> !ovf_q); // R9
endmodule

// File: tb/test_wide_ingress_fifo.sv
module test_wide_ingress_fifo;
  localparam int DEPTH = 8;

  logic       rst_ni = 1'b0;
  logic       in_clk = 1'b0, core_clk = 1'b0;
  logic       byte_valid = 1'b0, flush = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       word_ready = 1'b0, ovf_clr = 1'b0;
  logic       word_valid, word_half, ovf;
  logic [15:0] word_data;

  always #8  in_clk   = ~in_clk;    // input side, faster
  always #10 core_clk = ~core_clk;  // 50 MHz core side

  wide_ingress_fifo #(.DEPTH(DEPTH)) i_wide_ingress_fifo (
    .rst_ni       (rst_ni),
    .in_clk_i     (in_clk),
    .byte_valid_i (byte_valid),
    .byte_data_i  (byte_data),
    .flush_i      (flush),
    .core_clk_i   (core_clk),
    .word_valid_o (word_valid),
    .word_ready_i (word_ready),
    .word_data_o  (word_data),
    .word_half_o  (word_half),
    .ovf_o        (ovf),
    .ovf_clr_i    (ovf_clr)
  );

  int checks = 0, errors = 0, recv_cnt = 0, dropped = 0;
  bit mon_en = 1'b0, cap_en = 1'b0, done = 1'b0;
  logic [16:0] exp_q[$];
  logic [16:0] last_pop = '0;
  bit have_b = 1'b0;
  logic [7:0] lo_b = 8'h00;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_push(input logic [16:0] e);
    if (cap_en && exp_q.size() >= DEPTH + 1) dropped++;
    else exp_q.push_back(e);
  endfunction

  // one input-clock cycle of stimulus, with the behavioural packing model
  task automatic drive_in(input bit v, input logic [7:0] b, input bit fl);
    @(posedge in_clk); #2;
    byte_valid = v; byte_data = b; flush = fl;
    if (v) begin
      if (have_b) begin model_push({1'b0, b, lo_b}); have_b = 1'b0; end
      else if (fl) model_push({1'b1, 8'h00, b});
      else begin have_b = 1'b1; lo_b = b; end
    end else if (fl && have_b) begin
      model_push({1'b1, 8'h00, lo_b}); have_b = 1'b0;
    end
  endtask

  task automatic in_idle();
    drive_in(1'b0, 8'h00, 1'b0);
  endtask

  task automatic core_wait(input int n);
    repeat (n) begin @(posedge core_clk); #5; end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 400; i++) begin
      if (exp_q.size() == 0 && !word_valid) break;
      core_wait(1);
    end
    core_wait(3);
    check(exp_q.size() == 0 && !word_valid, "R6 drained queue leaves valid low",
          32'(word_valid), 32'(0));
  endtask

  // per-clock comparison of the presented word against the model head
  always @(negedge core_clk) begin
    if (mon_en && word_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 word with empty model", 32'({word_half, word_data}), 32'(0));
      end else begin
        check({word_half, word_data} == exp_q[0], "R1 R4 word content/order",
              32'({word_half, word_data}), 32'(exp_q[0]));
        if (word_ready) begin
          last_pop = exp_q.pop_front();
          recv_cnt++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge core_clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    logic [15:0] held;
    int base;
    // reset state
    core_wait(4);
    check(word_valid == 1'b0, "R6 reset valid", 32'(word_valid), 32'(0));
    check(ovf == 1'b0, "R6 reset ovf", 32'(ovf), 32'(0));
    @(negedge core_clk); rst_ni = 1'b1;
    core_wait(3);
    mon_en = 1'b1;
    word_ready = 1'b1;

    // R1: pair order
    drive_in(1, 8'h11, 0); drive_in(1, 8'h22, 0);
    drive_in(1, 8'h33, 0); drive_in(1, 8'h44, 0); in_idle();
    wait_drain();
    check(last_pop == 17'h04433, "R1 second pair", 32'(last_pop), 32'h04433);

    // R2: lone byte stays pending without flush
    drive_in(1, 8'h55, 0); in_idle();
    core_wait(30);
    check(word_valid == 1'b0, "R2 single byte held back", 32'(word_valid), 32'(0));
    drive_in(1, 8'h66, 0); in_idle();
    wait_drain();
    check(last_pop == 17'h06655, "R2 pair completed later", 32'(last_pop), 32'h06655);

    // R3: flush cases
    drive_in(1, 8'h01, 0); drive_in(1, 8'h02, 0); drive_in(1, 8'h03, 0);
    drive_in(0, 8'h00, 1); in_idle();
    wait_drain();
    check(last_pop == 17'h10003, "R3 flush pending byte", 32'(last_pop), 32'h10003);
    drive_in(1, 8'hA5, 1); in_idle();
    wait_drain();
    check(last_pop == 17'h100A5, "R3 byte with flush", 32'(last_pop), 32'h100A5);
    drive_in(1, 8'h10, 0); drive_in(1, 8'h20, 1); in_idle();
    wait_drain();
    check(last_pop == 17'h02010, "R3 flush on completing byte", 32'(last_pop), 32'h02010);
    base = recv_cnt;
    drive_in(0, 8'h00, 1); in_idle();
    core_wait(30);
    check(recv_cnt == base && !word_valid, "R3 empty flush adds nothing",
          32'(recv_cnt - base), 32'(0));

    // R5: hold and one-cycle advance
    word_ready = 1'b0;
    drive_in(1, 8'hEF, 0); drive_in(1, 8'hBE, 0);
    drive_in(1, 8'h0D, 0); drive_in(1, 8'hF0, 0); in_idle();
    core_wait(20);
    check(word_valid && word_data == 16'hBEEF, "R5 first word shown",
          32'(word_data), 32'hBEEF);
    held = word_data;
    core_wait(5);
    check(word_valid && word_data == held, "R5 held while not ready",
          32'(word_data), 32'(held));
    word_ready = 1'b1;
    @(posedge core_clk); #2; word_ready = 1'b0; #3;
    check(word_valid && word_data == 16'hF00D, "R5 next word one cycle after accept",
          32'(word_data), 32'hF00D);
    core_wait(1);
    word_ready = 1'b1;
    wait_drain();

    // R4: burst against a throttled reader
    base = recv_cnt;
    fork
      begin
        for (int i = 0; i < 12; i++) drive_in(1, 8'((i * 37 + 5) & 8'hFF), 0);
        in_idle();
      end
      begin
        for (int i = 0; i < 40; i++) begin core_wait(1); word_ready = (i % 3) != 0; end
        word_ready = 1'b1;
      end
    join
    wait_drain();
    check(recv_cnt - base == 6, "R4 burst word count", 32'(recv_cnt - base), 32'(6));

    // R7 / R8: overflow with reader stalled
    word_ready = 1'b0;
    base = recv_cnt;
    drive_in(1, 8'hC0, 0); drive_in(1, 8'hC1, 0); in_idle();
    core_wait(20);
    check(ovf == 1'b0, "R8 no overflow before burst", 32'(ovf), 32'(0));
    cap_en = 1'b1;
    for (int i = 0; i < 2 * (DEPTH + 3); i++) drive_in(1, 8'(8'h40 + i), 0);
    in_idle();
    core_wait(20);
    check(ovf == 1'b1, "R8 overflow flagged", 32'(ovf), 32'(1));
    word_ready = 1'b1;
    wait_drain();
    cap_en = 1'b0;
    check(recv_cnt - base == DEPTH + 1, "R7 words kept through overflow",
          32'(recv_cnt - base), 32'(DEPTH + 1));
    check(dropped == 3, "R7 model drop count", 32'(dropped), 32'(3));
    core_wait(10);
    check(ovf == 1'b1, "R8 flag sticky after drain", 32'(ovf), 32'(1));

    // R9: clear pulse
    ovf_clr = 1'b1; core_wait(1); ovf_clr = 1'b0;
    core_wait(15);
    check(ovf == 1'b0, "R9 flag cleared", 32'(ovf), 32'(0));
    drive_in(1, 8'h77, 0); drive_in(1, 8'h88, 0); in_idle();
    wait_drain();
    check(last_pop == 17'h08877, "R4 traffic after clear", 32'(last_pop), 32'h08877);
    check(ovf == 1'b0, "R9 flag stays low", 32'(ovf), 32'(0));
    check(exp_q.size() == 0, "R4 all words delivered", 32'(exp_q.size()), 32'(0));

    finish_run();
  end
endmodule